// File: doc/BRIEF.md
# Non-Blocking Load Miss Tracker

This block lets an in-order pipeline retire a load that has cleared address translation and its permission check but missed in the data cache, without waiting for the data. The missing load is parked in one of a small pool of tracking slots. Each slot records the cache line address, the word within the line and the destination register tag. A register scoreboard marks that destination as pending, so the pipeline halts only when a later instruction actually reads the pending register. Other instructions, stores included, keep moving and retiring. The load's permission check has already passed, so it cannot fault later. A pipeline flush never removes a slot, because the load that owns it has already retired.

When memory returns a line, every slot waiting on that line finishes in the same cycle. Each one drives its own writeback lane with the word it asked for and clears its pending mark. A new miss whose destination is already pending marks the older slot dead, so only the newest value reaches the register. The slots' line addresses are exported for store-conflict probing. A full flag reports that no slot is free.

Top module: `load_miss_tracker`

## Requirements
- R1: After reset, `full`, `stall`, every `wb_valid` bit and every `probe_valid` bit are 0.
- R2: A load presented with `ld_valid` while `full` is 0 is taken at the clock edge into the lowest-numbered free slot. From the next cycle, that slot's `probe_valid` bit is 1 and its `probe_line` field holds `ld_addr[ADDR_W-1:4]`. Slot i occupies bits `[i*LINE_W +: LINE_W]`.
- R3: From the cycle after a load is taken, `stall` is 1 in any cycle where an enabled `rd_en` port names its destination tag. A read of a tag that is not pending leaves `stall` at 0.
- R4: In a cycle where `fill_valid` is 1 and `fill_line` equals a live slot's line, that slot's `wb_valid` bit is 1 in the same cycle. Its `wb_tag` field gives the load's tag and its `wb_data` field gives word `ld_addr[3:2]` of `fill_data`, where word k is `fill_data[k*32 +: 32]`. From the next cycle the slot is free and its tag no longer stalls.
- R5: All slots that match one fill complete in that same cycle, each on its own writeback lane.
- R6: `full` is 1 exactly when every slot is busy. A load presented while `full` is 1 is not taken, and `stall` is 1 for that cycle.
- R7: When a load is taken whose tag matches a busy slot, the older slot's writeback is suppressed. The tag stays pending until the newest load's line returns.
- R8: A fill whose line matches no slot produces no writeback and changes no slot or pending mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load that passed its checks and missed in the cache |
| ld_addr | input | ADDR_W | Byte address of that load |
| ld_tag | input | TAG_W | Destination register of that load |
| rd_en | input | NUM_RD | Source-read enables from decode |
| rd_tag | input | NUM_RD*TAG_W | Source register tags from decode |
| fill_valid | input | 1 | A cache line returns from memory |
| fill_line | input | LINE_W | Line address of the returning line |
| fill_data | input | WORDS*DATA_W | Contents of the returning line |
| stall | output | 1 | Halt issue: pending source read, or a load arrived while full |
| full | output | 1 | No free slot |
| wb_valid | output | ENTRIES | Per-slot register writeback strobe |
| wb_tag | output | ENTRIES*TAG_W | Per-slot writeback register tag |
| wb_data | output | ENTRIES*DATA_W | Per-slot writeback data |
| probe_valid | output | ENTRIES | Slot busy, for store-conflict probing |
| probe_line | output | ENTRIES*LINE_W | Slot line addresses, for store-conflict probing |

## Verification
The hardest situation to reach is a single fill that retires several slots at once while another slot, waiting on a different line, must remain untouched. The stimulus fills every slot: one on an early line, then three on a shared line with different word offsets. It then presents one more load, which must be refused. It returns the shared line and checks three lanes against a queue of expected writebacks. The overwrite case is reached by issuing two misses to the same register on different lines and returning the older line first. The bench expects no writeback for it, and the register must still stall.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
  localparam int LMT_ENTRIES = 4;
  localparam int LMT_ADDR_W  = 32;
  localparam int LMT_DATA_W  = 32;
  localparam int LMT_WORDS   = 4;
  localparam int LMT_TAG_W   = 5;
  localparam int LMT_NUM_RD  = 2;
endpackage

// File: rtl/lmt_alloc.sv
module lmt_alloc #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy,
  input  logic         req,
  output logic [N-1:0] grant,
  output logic         full
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req && !busy[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign full = &busy;
endmodule

// File: rtl/lmt_entry.sv
module lmt_entry #(
  parameter int LINE_W = 28,
  parameter int WIDX_W = 2,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc,
  input  logic [LINE_W-1:0]       alloc_line,
  input  logic [WIDX_W-1:0]       alloc_widx,
  input  logic [TAG_W-1:0]        alloc_tag,
  input  logic                    kill,
  input  logic                    fill_valid,
  input  logic [LINE_W-1:0]       fill_line,
  input  logic [WORDS*DATA_W-1:0] fill_data,
  output logic                    busy,
  output logic [LINE_W-1:0]       line,
  output logic [TAG_W-1:0]        tag,
  output logic                    wb_valid,
  output logic [DATA_W-1:0]       wb_data
);
  logic              valid_q, valid_d;
  logic              live_q, live_d;
  logic [LINE_W-1:0] line_q;
  logic [WIDX_W-1:0] widx_q;
  logic [TAG_W-1:0]  tag_q;
  logic              hit;

  assign hit      = valid_q && fill_valid && (fill_line == line_q);
  assign wb_valid = hit && live_q && !kill;
  assign wb_data  = fill_data[widx_q*DATA_W +: DATA_W];
  assign busy     = valid_q;
  assign line     = line_q;
  assign tag      = tag_q;

  always_comb begin
    valid_d = valid_q;
    live_d  = live_q;
    if (hit)   valid_d = 1'b0;
    if (kill)  live_d  = 1'b0;
    if (alloc) begin
      valid_d = 1'b1;
      live_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      live_q  <= live_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      line_q <= alloc_line;
      widx_q <= alloc_widx;
      tag_q  <= alloc_tag;
    end
  end

  AST_WB_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !valid_q); // R4

  AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !hit) |=> (valid_q && $stable(line_q))); // R2
endmodule

// File: rtl/lmt_score.sv
module lmt_score #(
  parameter int TAG_W  = 5,
  parameter int NUM_RD = 2,
  parameter int N      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [TAG_W-1:0]      set_tag,
  input  logic [N-1:0]          clr_en,
  input  logic [N*TAG_W-1:0]    clr_tag,
  input  logic [NUM_RD-1:0]     rd_en,
  input  logic [NUM_RD*TAG_W-1:0] rd_tag,
  output logic                  hazard
);
  localparam int REGS = 1 << TAG_W;

  logic [REGS-1:0]   pend_q, pend_d;
  logic [NUM_RD-1:0] rd_hit;

  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < N; i++) begin
      if (clr_en[i]) pend_d[clr_tag[i*TAG_W +: TAG_W]] = 1'b0;
    end
    if (set_en) pend_d[set_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_hit[r] = rd_en[r] && pend_q[rd_tag[r*TAG_W +: TAG_W]];
  end

  assign hazard = |rd_hit;

  AST_PEND_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> pend_q[$past(set_tag)]); // R3
endmodule

// File: rtl/load_miss_tracker.sv
module load_miss_tracker
  import lmt_pkg::*;
#(
  parameter int ENTRIES = LMT_ENTRIES,
  parameter int ADDR_W  = LMT_ADDR_W,
  parameter int DATA_W  = LMT_DATA_W,
  parameter int WORDS   = LMT_WORDS,
  parameter int TAG_W   = LMT_TAG_W,
  parameter int NUM_RD  = LMT_NUM_RD,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFS_W  = WIDX_W + BYTE_W,
  localparam int LINE_W = ADDR_W - OFS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [TAG_W-1:0]          ld_tag,
  input  logic [NUM_RD-1:0]         rd_en,
  input  logic [NUM_RD*TAG_W-1:0]   rd_tag,
  input  logic                      fill_valid,
  input  logic [LINE_W-1:0]         fill_line,
  input  logic [WORDS*DATA_W-1:0]   fill_data,
  output logic                      stall,
  output logic                      full,
  output logic [ENTRIES-1:0]        wb_valid,
  output logic [ENTRIES*TAG_W-1:0]  wb_tag,
  output logic [ENTRIES*DATA_W-1:0] wb_data,
  output logic [ENTRIES-1:0]        probe_valid,
  output logic [ENTRIES*LINE_W-1:0] probe_line
);
  logic [ENTRIES-1:0] busy, grant, kill;
  logic               take, hazard;
  logic [LINE_W-1:0]  ld_line;
  logic [WIDX_W-1:0]  ld_widx;

  assign ld_line = ld_addr[ADDR_W-1:OFS_W];
  assign ld_widx = ld_addr[OFS_W-1:BYTE_W];
  assign take    = ld_valid && !full;

  lmt_alloc #(.N(ENTRIES)) u_alloc (
    .busy  (busy),
    .req   (take),
    .grant (grant),
    .full  (full)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic [TAG_W-1:0] slot_tag;

    assign kill[i] = take && busy[i] && (slot_tag == ld_tag);

    lmt_entry #(
      .LINE_W (LINE_W),
      .WIDX_W (WIDX_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W),
      .WORDS  (WORDS)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (grant[i]),
      .alloc_line (ld_line),
      .alloc_widx (ld_widx),
      .alloc_tag  (ld_tag),
      .kill       (kill[i]),
      .fill_valid (fill_valid),
      .fill_line  (fill_line),
      .fill_data  (fill_data),
      .busy       (busy[i]),
      .line       (probe_line[i*LINE_W +: LINE_W]),
      .tag        (slot_tag),
      .wb_valid   (wb_valid[i]),
      .wb_data    (wb_data[i*DATA_W +: DATA_W])
    );

    assign wb_tag[i*TAG_W +: TAG_W] = slot_tag;
  end

  lmt_score #(.TAG_W(TAG_W), .NUM_RD(NUM_RD), .N(ENTRIES)) u_score (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (take),
    .set_tag (ld_tag),
    .clr_en  (wb_valid),
    .clr_tag (wb_tag),
    .rd_en   (rd_en),
    .rd_tag  (rd_tag),
    .hazard  (hazard)
  );

  assign stall       = hazard || (ld_valid && full);
  assign probe_valid = busy;

  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && full && !fill_valid) |=> (busy == $past(busy))); // R6

  AST_TAKE_FILLS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !full) |=> ($countones(busy) >= 1)); // R2
endmodule

// File: tb/sim_load_miss_tracker.sv
module sim_load_miss_tracker;
  localparam int N = 4;
  localparam int TW = 5;
  localparam int LW = 28;

  logic         clk, rst_n;
  logic         ld_valid;
  logic [31:0]  ld_addr;
  logic [4:0]   ld_tag;
  logic [1:0]   rd_en;
  logic [9:0]   rd_tag;
  logic         fill_valid;
  logic [27:0]  fill_line;
  logic [127:0] fill_data;
  logic         stall, full;
  logic [3:0]   wb_valid, probe_valid;
  logic [19:0]  wb_tag;
  logic [127:0] wb_data;
  logic [111:0] probe_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [4:0]  q_tag[$];
  logic [31:0] q_data[$];
  string       q_req[$];

  load_miss_tracker u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .rd_en(rd_en), .rd_tag(rd_tag), .fill_valid(fill_valid), .fill_line(fill_line),
    .fill_data(fill_data), .stall(stall), .full(full), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .wb_data(wb_data), .probe_valid(probe_valid), .probe_line(probe_line)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [27:0] line, input int k);
    return 32'hA000_0000 | {12'h0, line[15:0], 4'h0} | 32'(k);
  endfunction

  function automatic logic [127:0] line_data(input logic [27:0] line);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[k*32 +: 32] = word_of(line, k);
    return d;
  endfunction

  task automatic expect_wb(input logic [4:0] t, input logic [27:0] line, input int k, input string req);
    q_tag.push_back(t);
    q_data.push_back(word_of(line, k));
    q_req.push_back(req);
  endtask

  task automatic issue(input logic [27:0] line, input logic [1:0] w, input logic [4:0] t);
    @(posedge clk); #2;
    ld_valid = 1; ld_addr = {line, w, 2'b00}; ld_tag = t;
    @(posedge clk); #2;
    ld_valid = 0;
  endtask

  task automatic fill(input logic [27:0] line);
    @(posedge clk); #2;
    fill_valid = 1; fill_line = line; fill_data = line_data(line);
    @(posedge clk); #2;
    fill_valid = 0;
  endtask

  task automatic read_tag(input logic [4:0] t);
    rd_en = 2'b01; rd_tag = {5'd0, t};
  endtask

  // monitor: compares writebacks against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (wb_valid[i]) begin
          if (q_tag.size() == 0) begin
            chk(0, "R8 unexpected writeback", {32'(wb_tag[i*TW +: TW]), wb_data[i*32 +: 32]}, 64'h0);
          end else begin
            logic [4:0] et; logic [31:0] ed; string er;
            et = q_tag.pop_front(); ed = q_data.pop_front(); er = q_req.pop_front();
            chk(wb_tag[i*TW +: TW] == et && wb_data[i*32 +: 32] == ed, er,
                {32'(wb_tag[i*TW +: TW]), wb_data[i*32 +: 32]}, {32'(et), ed});
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_valid = 0; ld_addr = 0; ld_tag = 0; rd_en = 0; rd_tag = 0;
    fill_valid = 0; fill_line = 0; fill_data = 0;
    repeat (3) @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk(full == 0 && stall == 0 && wb_valid == 0 && probe_valid == 0, "R1 reset state",
        {full, stall, wb_valid, probe_valid}, 0);

    // single miss, then return
    issue(28'h100_0000, 2'd1, 5'd5);
    @(negedge clk);
    chk(probe_valid == 4'b0001, "R2 slot0 busy", probe_valid, 4'b0001);
    chk(probe_line[0 +: LW] == 28'h100_0000, "R2 probe line", probe_line[0 +: LW], 28'h100_0000);
    read_tag(5'd5); #1;
    chk(stall == 1, "R3 pending read stalls", stall, 1);
    read_tag(5'd6); #1;
    chk(stall == 0, "R3 free read flows", stall, 0);
    rd_en = 0;
    expect_wb(5'd5, 28'h100_0000, 1, "R4 single fill writeback");
    fill(28'h100_0000);
    @(negedge clk);
    read_tag(5'd5); #1;
    chk(stall == 0, "R4 pending cleared", stall, 0);
    chk(probe_valid == 0, "R4 slot freed", probe_valid, 0);
    rd_en = 0;

    // unrelated fill
    issue(28'h200_0010, 2'd0, 5'd7);
    fill(28'h300_0020);
    @(negedge clk);
    chk(probe_valid == 4'b0001 && probe_line[0 +: LW] == 28'h200_0010, "R8 slot untouched",
        {probe_valid, probe_line[0 +: LW]}, {4'b0001, 28'h200_0010});
    read_tag(5'd7); #1;
    chk(stall == 1, "R8 pending kept", stall, 1);
    rd_en = 0;

    // fill the pool, three slots share a line
    issue(28'h400_0040, 2'd0, 5'd8);
    issue(28'h400_0040, 2'd2, 5'd9);
    issue(28'h400_0040, 2'd3, 5'd10);
    @(negedge clk);
    chk(full == 1, "R6 full flag", full, 1);
    @(posedge clk); #2;
    ld_valid = 1; ld_addr = {28'h500_0050, 4'h0}; ld_tag = 5'd11;
    @(negedge clk);
    chk(stall == 1, "R6 load while full stalls", stall, 1);
    @(posedge clk); #2 ld_valid = 0;
    @(negedge clk);
    read_tag(5'd11); #1;
    chk(stall == 0, "R6 refused load not pending", stall, 0);
    rd_en = 0;
    chk(probe_line[3*LW +: LW] == 28'h400_0040, "R6 slots unchanged", probe_line[3*LW +: LW], 28'h400_0040);

    expect_wb(5'd8,  28'h400_0040, 0, "R5 multi lane 1");
    expect_wb(5'd9,  28'h400_0040, 2, "R5 multi lane 2");
    expect_wb(5'd10, 28'h400_0040, 3, "R5 multi lane 3");
    fill(28'h400_0040);
    @(negedge clk);
    chk(probe_valid == 4'b0001 && full == 0, "R5 three slots freed", {full, probe_valid}, 4'b0001);
    expect_wb(5'd7, 28'h200_0010, 0, "R4 remaining slot");
    fill(28'h200_0010);

    // overwrite of a pending register
    issue(28'h600_0060, 2'd1, 5'd12);
    issue(28'h700_0070, 2'd2, 5'd12);
    fill(28'h600_0060);
    @(negedge clk);
    read_tag(5'd12); #1;
    chk(stall == 1, "R7 newer load still pending", stall, 1);
    rd_en = 0;
    chk(q_tag.size() == 0, "R7 older writeback suppressed", q_tag.size(), 0);
    expect_wb(5'd12, 28'h700_0070, 2, "R7 newest value written");
    fill(28'h700_0070);
    @(negedge clk);
    read_tag(5'd12); #1;
    chk(stall == 0, "R7 pending cleared", stall, 0);
    rd_en = 0;

    repeat (2) @(negedge clk);
    chk(q_tag.size() == 0, "R4 all writebacks seen", q_tag.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule